// File: doc/BRIEF.md
# Interleaved Variable-Period Totem-Pole PWM Generator

This block drives the six gates of a two-phase interleaved totem-pole bridgeless power-factor-correction stage. There are two fast legs, each with a high and a low switch, and one line-frequency leg. Upstream control computes a switching period and a main-switch on-time, both in clock counts, once per switching cycle. It hands the pair over on a valid/ready stream. The block takes one pair at each cycle boundary, so the switching frequency can change from one cycle to the next. When no new pair is waiting, the block repeats the pair already in force.

Phase A starts its cycle at the boundary. Phase B uses the same on-time and starts half of the period in force later. In each fast leg the rectifier switch is the complement of the main switch, with a programmable dead time around every edge. The rectifier stays on up to the end of the period. It is not cut off when the inductor current falls to zero, so the extra conduction builds the negative bias current that the main switch needs to turn on at zero voltage. The period chosen upstream sets how long that extra interval lasts.

A line-polarity input decides which line-leg switch is on, and whether the low or the high fast switch acts as the main switch. Enable low forces every gate off.

Stream rules:
- A pair is accepted on a clock edge where both `cfg_valid` and `cfg_ready` are high.
- After an accept, `cfg_ready` stays low until the next cycle boundary consumes the stored pair. At most one pair therefore waits at a time.
- A pair may be loaded while enable is low. It is then used by the first cycle after enable rises.

Top module: `tpfc_pwm_gen`

## Requirements
- R1: While reset is asserted, and on the first edge on which `en` is sampled low, all six gate outputs are 0. `cfg_ready` is 1 after reset.
- R2: The period/on-time pair accepted on the stream is applied from the next cycle boundary for exactly one cycle when a further pair follows. `cfg_ready` is 0 from the accepting edge until that boundary.
- R3: The period is clamped to [PER_MIN, PER_MAX]. With the defaults this is 1000 to 5000 counts, which is 200 kHz down to 40 kHz at a 200 MHz clock.
- R4: The on-time is clamped so that on-time plus twice the dead time never exceeds the period.
- R5: In each phase, the main switch turns on one dead time after the start of that phase's cycle and stays on for exactly the on-time.
- R6: The rectifier switch of a leg turns on one dead time after the main switch turns off. It stays on until the end of the period, which gives a width of period − on − 2·dead, and then one dead time passes before the next main pulse. A dead-time input of 0 is used as 1.
- R7: The main pulse of phase B rises floor(P/2) counts after the main pulse of phase A, where P is the period in force.
- R8: With `pol_neg` = 0, `fast_lo` is the main switch, `fast_hi` is the rectifier and `line_lo` is on. With `pol_neg` = 1, `fast_hi` is the main switch, `fast_lo` is the rectifier and `line_hi` is on.
- R9: A change of `pol_neg` has no effect until the next cycle boundary. In that changeover cycle, all fast and line gates stay off for the first dead-time counts.
- R10: When `en` returns high, phase A restarts at count 0 and phase B starts half a period later.
- R11: The high and low switches of a leg (both fast legs and the line leg) are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all gates off |
| pol_neg | input | 1 | Line polarity: 0 positive half cycle, 1 negative |
| dead_cnt | input | DT_W | Dead time in clock counts, sampled at each cycle boundary |
| cfg_valid | input | 1 | Period/on-time pair valid |
| cfg_ready | output | 1 | Holding slot empty, pair can be accepted |
| cfg_period | input | CNT_W | Switching period in counts |
| cfg_on | input | CNT_W | Main-switch on-time in counts |
| fast_hi | output | 2 | High fast switch gate, one bit per phase |
| fast_lo | output | 2 | Low fast switch gate, one bit per phase |
| line_hi | output | 1 | High line-frequency switch gate |
| line_lo | output | 1 | Low line-frequency switch gate |

## Verification
Two events can land on one cycle boundary: a polarity changeover and the load of a new period/on-time pair. The bench provokes this by writing a new pair just after a main pulse starts and flipping the polarity in the same cycle.

The result is judged at the ports on four points:
- the line leg is off for exactly one dead time;
- every fast gate stays off during that window;
- the main pulse then appears on the high switch with the right width;
- phase B's offset on the following restart matches half of the newly loaded period.

// File: rtl/tpfc_pkg.sv
package tpfc_pkg;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} line_pol_e;

  typedef struct packed {
    logic main;
    logic rect;
  } leg_drv_t;
endpackage

// File: rtl/tpfc_cfg_slot.sv
module tpfc_cfg_slot #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_per,
  input  logic [CNT_W-1:0] in_on,
  input  logic             take,
  output logic             held,
  output logic [CNT_W-1:0] out_per,
  output logic [CNT_W-1:0] out_on
);
  logic full;

  assign in_ready = !full;
  assign held     = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      out_per <= '0;
      out_on  <= '0;
    end else if (in_valid && !full) begin
      full    <= 1'b1;
      out_per <= in_per;
      out_on  <= in_on;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/tpfc_cycle_timer.sv
module tpfc_cycle_timer
  import tpfc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DT_W    = 8,
  parameter int PER_MIN = 1000,
  parameter int PER_MAX = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol_in,
  input  logic [DT_W-1:0]  dead_in,
  input  logic             slot_held,
  input  logic [CNT_W-1:0] slot_per,
  input  logic [CNT_W-1:0] slot_on,
  output logic             slot_take,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] half_m1,
  output logic [CNT_W-1:0] on_a,
  output logic [CNT_W-1:0] dt_a,
  output line_pol_e        pol_a,
  output logic             blank_now
);
  localparam int W2 = CNT_W + 1;
  localparam logic [CNT_W-1:0] PMIN_C = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] PMAX_C = CNT_W'(PER_MAX);

  logic [CNT_W-1:0] per_a, src_per, src_on, per_c, dt_c, lim, on_c;
  logic [W2-1:0]    two_dt;
  logic             blank_r, boundary, start;

  assign boundary  = run && (cnt == per_a - 1'b1);
  assign start     = en && (!run || boundary);
  assign slot_take = start && slot_held;
  assign half_m1   = (per_a >> 1) - 1'b1;
  assign blank_now = blank_r && (cnt < dt_a);

  always_comb begin
    src_per = slot_held ? slot_per : per_a;
    src_on  = slot_held ? slot_on : on_a;
    if (src_per < PMIN_C)      per_c = PMIN_C;
    else if (src_per > PMAX_C) per_c = PMAX_C;
    else                       per_c = src_per;
    dt_c   = (dead_in == '0) ? CNT_W'(1) : CNT_W'(dead_in);
    two_dt = {1'b0, dt_c} << 1;
    if (two_dt >= {1'b0, per_c}) lim = '0;
    else                         lim = per_c - two_dt[CNT_W-1:0];
    on_c   = (src_on > lim) ? lim : src_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      per_a   <= PMAX_C;
      on_a    <= '0;
      dt_a    <= CNT_W'(1);
      pol_a   <= POL_POS;
      blank_r <= 1'b0;
    end else if (!en) begin
      run     <= 1'b0;
      cnt     <= '0;
      blank_r <= 1'b0;
    end else if (start) begin
      run     <= 1'b1;
      cnt     <= '0;
      per_a   <= per_c;
      on_a    <= on_c;
      dt_a    <= dt_c;
      pol_a   <= line_pol_e'(pol_in);
      blank_r <= !run || (line_pol_e'(pol_in) != pol_a);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tpfc_phase_follow.sv
module tpfc_phase_follow #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             a_run,
  input  logic [CNT_W-1:0] a_cnt,
  input  logic [CNT_W-1:0] a_half_m1,
  input  logic [CNT_W-1:0] a_on,
  input  logic [CNT_W-1:0] a_dt,
  output logic             b_run,
  output logic [CNT_W-1:0] b_cnt,
  output logic [CNT_W-1:0] b_on,
  output logic [CNT_W-1:0] b_dt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_run <= 1'b0;
      b_cnt <= '0;
      b_on  <= '0;
      b_dt  <= CNT_W'(1);
    end else if (!en) begin
      b_run <= 1'b0;
      b_cnt <= '0;
    end else if (a_run && (a_cnt == a_half_m1)) begin
      b_run <= 1'b1;
      b_cnt <= '0;
      b_on  <= a_on;
      b_dt  <= a_dt;
    end else if (b_run) begin
      b_cnt <= b_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tpfc_leg_window.sv
module tpfc_leg_window
  import tpfc_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_cnt,
  input  logic [CNT_W-1:0] dt_cnt,
  output leg_drv_t         drv
);
  localparam int W2 = CNT_W + 1;

  logic [W2-1:0] c_w, main_end, rect_start;

  always_comb begin
    c_w        = {1'b0, cnt};
    main_end   = {1'b0, dt_cnt} + {1'b0, on_cnt};
    rect_start = {1'b0, on_cnt} + ({1'b0, dt_cnt} << 1);
    drv.main   = active && (cnt >= dt_cnt) && (c_w < main_end);
    drv.rect   = active && (c_w >= rect_start);
  end
endmodule

// File: rtl/tpfc_pwm_gen.sv
module tpfc_pwm_gen
  import tpfc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DT_W    = 8,
  parameter int PER_MIN = 1000,
  parameter int PER_MAX = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol_neg,
  input  logic [DT_W-1:0]  dead_cnt,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_on,
  output logic [1:0]       fast_hi,
  output logic [1:0]       fast_lo,
  output logic             line_hi,
  output logic             line_lo
);
  localparam int NLEG = 2;

  logic             held, take, a_run, b_run, blank_now;
  logic [CNT_W-1:0] s_per, s_on, a_cnt, a_half_m1, a_on, a_dt;
  logic [CNT_W-1:0] b_cnt, b_on, b_dt;
  line_pol_e        pol_a;

  logic             act_l [NLEG];
  logic [CNT_W-1:0] cnt_l [NLEG];
  logic [CNT_W-1:0] on_l  [NLEG];
  logic [CNT_W-1:0] dt_l  [NLEG];
  leg_drv_t         drv_l [NLEG];

  tpfc_cfg_slot #(.CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(cfg_valid), .in_ready(cfg_ready),
    .in_per(cfg_period), .in_on(cfg_on), .take(take), .held(held),
    .out_per(s_per), .out_on(s_on)
  );

  tpfc_cycle_timer #(.CNT_W(CNT_W), .DT_W(DT_W), .PER_MIN(PER_MIN),
                     .PER_MAX(PER_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .pol_in(pol_neg), .dead_in(dead_cnt),
    .slot_held(held), .slot_per(s_per), .slot_on(s_on), .slot_take(take),
    .run(a_run), .cnt(a_cnt), .half_m1(a_half_m1), .on_a(a_on), .dt_a(a_dt),
    .pol_a(pol_a), .blank_now(blank_now)
  );

  tpfc_phase_follow #(.CNT_W(CNT_W)) u_follow (
    .clk(clk), .rst_n(rst_n), .en(en), .a_run(a_run), .a_cnt(a_cnt),
    .a_half_m1(a_half_m1), .a_on(a_on), .a_dt(a_dt),
    .b_run(b_run), .b_cnt(b_cnt), .b_on(b_on), .b_dt(b_dt)
  );

  assign act_l[0] = a_run;
  assign cnt_l[0] = a_cnt;
  assign on_l[0]  = a_on;
  assign dt_l[0]  = a_dt;
  assign act_l[1] = b_run;
  assign cnt_l[1] = b_cnt;
  assign on_l[1]  = b_on;
  assign dt_l[1]  = b_dt;

  for (genvar gi = 0; gi < NLEG; gi++) begin : g_leg
    tpfc_leg_window #(.CNT_W(CNT_W)) u_win (
      .active(act_l[gi]), .cnt(cnt_l[gi]), .on_cnt(on_l[gi]),
      .dt_cnt(dt_l[gi]), .drv(drv_l[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_hi <= '0;
      fast_lo <= '0;
      line_hi <= 1'b0;
      line_lo <= 1'b0;
    end else if (!en) begin
      fast_hi <= '0;
      fast_lo <= '0;
      line_hi <= 1'b0;
      line_lo <= 1'b0;
    end else begin
      for (int i = 0; i < NLEG; i++) begin
        fast_hi[i] <= !blank_now &&
                      ((pol_a == POL_NEG) ? drv_l[i].main : drv_l[i].rect);
        fast_lo[i] <= !blank_now &&
                      ((pol_a == POL_NEG) ? drv_l[i].rect : drv_l[i].main);
      end
      line_hi <= a_run && !blank_now && (pol_a == POL_NEG);
      line_lo <= a_run && !blank_now && (pol_a == POL_POS);
    end
  end
endmodule

// File: rtl/tpfc_pwm_gen_chk.sv
module tpfc_pwm_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic [1:0] fast_hi,
  input logic [1:0] fast_lo,
  input logic       line_hi,
  input logic       line_lo
);
  p_leg_a_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_hi[0] && fast_lo[0]));
  p_leg_b_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_hi[1] && fast_lo[1]));
  p_line_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo));
  p_off_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fast_hi == 2'b00 && fast_lo == 2'b00 && !line_hi && !line_lo));
  p_ready_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> !cfg_ready);
  p_gap_hi_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_hi[0]) |-> !$past(fast_lo[0]));
  p_gap_lo_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_lo[1]) |-> !$past(fast_hi[1]));
  p_line_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_hi) |-> !$past(line_lo));
endmodule

bind tpfc_pwm_gen tpfc_pwm_gen_chk u_chk (.*);

// File: tb/tpfc_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module tpfc_pwm_gen_tb_top;
  localparam int CW = 14, DW = 8, PMIN = 1000, PMAX = 5000, DT = 20;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pol_neg = 1'b0, cfg_valid = 1'b0;
  logic [DW-1:0] dead_cnt = DW'(DT);
  logic [CW-1:0] cfg_period = '0, cfg_on = '0;
  logic cfg_ready, line_hi, line_lo;
  logic [1:0] fast_hi, fast_lo;

  tpfc_pwm_gen #(.CNT_W(CW), .DT_W(DW), .PER_MIN(PMIN), .PER_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pol_neg(pol_neg), .dead_cnt(dead_cnt),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_period(cfg_period),
    .cfg_on(cfg_on), .fast_hi(fast_hi), .fast_lo(fast_lo),
    .line_hi(line_hi), .line_lo(line_lo)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, overlaps = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // 0 A_lo, 1 A_hi, 2 B_lo, 3 B_hi, 4 line_lo, 5 line_hi
  wire [5:0] g = {line_hi, line_lo, fast_hi[1], fast_lo[1], fast_hi[0], fast_lo[0]};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && ((fast_hi[0] && fast_lo[0]) || (fast_hi[1] && fast_lo[1]) ||
                  (line_hi && line_lo)))
      overlaps++;

  typedef struct {int per; int on;} exp_t;
  exp_t q[$];
  bit mon_on = 0, a_have = 0, b_seen = 0;
  logic a_prev = 1'b0, b_prev = 1'b0;
  int a_rise_t = 0, a_w = 0, b_rise_t = 0;

  // scoreboard monitor: phase A main on fast_lo[0], phase B main on fast_lo[1]
  always @(negedge clk) begin
    if (mon_on) begin
      if (g[0] && !a_prev) begin
        if (a_have && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(a_w == e.on, "R4 R5 main width", a_w, e.on);
          check(cyc - a_rise_t == e.per, "R2 R3 period", cyc - a_rise_t, e.per);
          check(b_seen && (b_rise_t - a_rise_t == e.per / 2), "R7 phase B offset",
                b_seen ? b_rise_t - a_rise_t : -1, e.per / 2);
        end
        a_have = 1;
        a_rise_t = cyc;
        b_seen = 0;
      end
      if (!g[0] && a_prev) a_w = cyc - a_rise_t;
      if (g[2] && !b_prev && a_have && !b_seen) begin
        b_seen = 1;
        b_rise_t = cyc;
      end
    end else begin
      a_have = 0;
    end
    a_prev = g[0];
    b_prev = g[2];
  end

  function automatic exp_t exp_of(input int p, input int o);
    exp_t e;
    e.per = (p < PMIN) ? PMIN : ((p > PMAX) ? PMAX : p);
    e.on  = (o > e.per - 2 * DT) ? e.per - 2 * DT : o;
    return e;
  endfunction

  task automatic send_cfg(input int p, input int o, input bit sb);
    int n = 0;
    while (!cfg_ready && n < 20000) begin @(negedge clk); n++; end
    cfg_period = CW'(p);
    cfg_on = CW'(o);
    cfg_valid = 1'b1;
    if (sb) q.push_back(exp_of(p, o));
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_level(input int idx, input logic v, output int t);
    int n = 0;
    while (g[idx] !== v && n < 20000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic wait_rise(input int idx, output int t);
    wait_level(idx, 1'b0, t);
    wait_level(idx, 1'b1, t);
  endtask

  initial begin
    int t1, t2, t3, t4, t5, tf, tg, tr, n;
    bit fb;
    repeat (4) @(negedge clk);
    check(g == 6'b0, "R1 gates in reset", int'(g), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(g == 6'b0, "R1 gates with en low", int'(g), 0);
    check(cfg_ready == 1'b1, "R1 ready after reset", int'(cfg_ready), 1);

    // scoreboard run, positive polarity
    mon_on = 1;
    send_cfg(2000, 600, 1);
    check(cfg_ready == 1'b0, "R2 back-pressure while held", int'(cfg_ready), 0);
    en = 1'b1;
    send_cfg(1500, 400, 1);
    send_cfg(3000, 1500, 1);
    send_cfg(1000, 2000, 1);
    send_cfg(500, 100, 1);
    send_cfg(9000, 300, 1);
    send_cfg(1200, 50, 1);
    n = 0;
    while (q.size() > 0 && n < 30000) begin @(negedge clk); n++; end
    check(q.size() == 0, "R2 every loaded cycle observed", q.size(), 0);
    mon_on = 0;
    en = 1'b0;
    @(negedge clk);

    // complementary drive and dead time
    send_cfg(2000, 600, 0);
    en = 1'b1;
    wait_rise(0, t1);
    wait_level(0, 1'b0, t2);
    check(t2 - t1 == 600, "R5 main width", t2 - t1, 600);
    wait_level(1, 1'b1, t3);
    check(t3 - t2 == DT, "R6 main-off to rect-on", t3 - t2, DT);
    wait_level(1, 1'b0, t4);
    check(t4 - t3 == 1360, "R6 rect runs to period end", t4 - t3, 1360);
    wait_level(0, 1'b1, t5);
    check(t5 - t4 == DT, "R6 rect-off to main-on", t5 - t4, DT);
    check(line_lo && !line_hi, "R8 positive line leg", int'(g[5:4]), 1);

    // changeover with a new pair landing at the same boundary
    send_cfg(1600, 600, 0);
    pol_neg = 1'b1;
    @(negedge clk);
    check(line_lo && !line_hi, "R9 polarity held until boundary", int'(g[5:4]), 1);
    wait_level(4, 1'b0, t1);
    n = 0;
    fb = 0;
    while (!line_hi && n < 10000) begin
      if (g[3:0] != 4'b0) fb = 1;
      @(negedge clk);
      n++;
    end
    check(n == DT, "R9 changeover blank length", n, DT);
    check(fb == 0, "R9 fast gates off in blank", int'(fb), 0);
    check(line_hi && !line_lo, "R8 negative line leg", int'(g[5:4]), 2);
    tr = cyc;
    check(g[1] == 1'b1, "R8 main on high switch", int'(g[1]), 1);
    wait_level(1, 1'b0, tf);
    check(tf - tr == 600, "R8 negative main width", tf - tr, 600);
    wait_level(0, 1'b1, tg);
    check(tg - tf == DT, "R8 R6 rect on low switch", tg - tf, DT);

    // disable and synchronised restart
    en = 1'b0;
    @(negedge clk);
    check(g == 6'b0, "R1 R10 off after en low", int'(g), 0);
    repeat (10) @(negedge clk);
    check(g == 6'b0, "R10 off while disabled", int'(g), 0);
    en = 1'b1;
    wait_rise(1, t1);
    wait_rise(3, t2);
    check(t2 - t1 == 800, "R7 R10 restart offset", t2 - t1, 800);
    en = 1'b0;
    repeat (3) @(negedge clk);

    check(overlaps == 0, "R11 leg overlap cycles", overlaps, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule